// File: doc/BRIEF.md
# Serialized Memory Stage for a Two-Wide In-Order Pipeline

This block sits between execute and writeback in a pipeline that moves two instructions at a time. Each cycle it can take a pair from execute. Lane 0 holds the older instruction and lane 1 the younger. Every lane carries a valid bit, a flag saying whether it touches memory, a flag saying whether that access misses the cache, and a tag. The block has one memory port. At most one access is in flight, and its length depends on hit or miss. Instructions that do not touch memory need only one cycle.

The block holds a pair until both of its instructions have left. It hands tags to writeback strictly oldest first, and up to two tags can leave in the same cycle. While any instruction of the current pair is still inside, the block refuses a new pair. Cache contents, addresses and data are not modelled: hit or miss arrives as an input flag.

Timing is counted from acceptance. A pair is taken at the clock edge where `in_ready` is high. The cycle after that edge is the first cycle of the pair, and an instruction that completes in that cycle shows on the writeback outputs during it.

Top module: `mem_stage_serializer`

## Requirements
- R1: After synchronous reset both stage slots are empty, so `wb_v` is 2'b00 and `in_ready` is 1.
- R2: An instruction whose memory flag is 0 leaves in the first cycle after acceptance, unless it must wait for an older instruction (R6).
- R3: A memory access with miss flag 0 takes one cycle. When served as soon as it is accepted, it leaves in the first cycle.
- R4: A memory access with miss flag 1 takes six cycles. An internal counter loads 5 when the access starts, counts down once per cycle, and the access completes in the cycle it reads 0.
- R5: Only one access uses the memory port at a time. If both lanes access memory, the lane-1 access starts in the cycle after the lane-0 access completes, so the two never leave together.
- R6: Writeback order is program order. Lane 1 leaves only in the same cycle as lane 0 or after it, and a completed younger instruction waits behind a pending older access.
- R7: `in_ready` is 0 in every cycle in which some instruction of the held pair does not leave. Inputs offered in such a cycle are ignored, so the held tags and timing are unchanged.
- R8: When lane 0 is a non-memory instruction or is invalid, a lane-1 access starts at once. A lane-1 miss then leaves in the sixth cycle.
- R9: A pair with no valid lane is accepted and leaves nothing. `in_ready` stays 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_v | input | 2 | Lane valid bits from execute (bit 0 older) |
| in_mem | input | 2 | Lane touches memory |
| in_miss | input | 2 | Lane's access misses the cache |
| in_tag0 | input | TAG_W | Tag of lane 0 |
| in_tag1 | input | TAG_W | Tag of lane 1 |
| in_ready | output | 1 | Stage takes a new pair at this edge |
| wb_v | output | 2 | Lane leaves to writeback this cycle |
| wb_tag0 | output | TAG_W | Tag of the held lane 0 |
| wb_tag1 | output | TAG_W | Tag of the held lane 1 |

## Verification
The assertions assume execute never drops a pair: a pair shown while `in_ready` is 0 is simply offered again later. They also assume that the miss flag is meaningful only when the memory flag is set. The stimulus waits for `in_ready` before presenting each pair. During stall cycles it deliberately drives random valid-looking pairs, which must be ignored. Lane flags are drawn at random, including pairs with invalid lanes and non-memory lanes that carry a miss flag.

// File: rtl/mss_pkg.sv
package mss_pkg;

  // Extra cycles an access occupies the port beyond its first cycle.
  function automatic int access_extra(input logic miss, input int miss_cyc, input int hit_cyc);
    return miss ? (miss_cyc - 1) : (hit_cyc - 1);
  endfunction

  function automatic int cnt_width(input int miss_cyc, input int hit_cyc);
    int m;
    m = (miss_cyc > hit_cyc) ? miss_cyc : hit_cyc;
    return (m <= 2) ? 1 : $clog2(m);
  endfunction

endpackage

// File: rtl/mss_port_timer.sv
module mss_port_timer #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          handoff,
  input  logic [CW-1:0] handoff_val,
  output logic [CW-1:0] cnt,
  output logic          cnt_zero
);

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
    else if (handoff)       cnt <= handoff_val;
  end

  assign cnt_zero = (cnt == '0);

  // R4: an access in progress counts down one step per cycle
  p_count_down_r4: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/mss_retire.sv
module mss_retire (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] v,
  input  logic [1:0] mem,
  input  logic       cnt_zero,
  output logic [1:0] leave,
  output logic       handoff,
  output logic       stay
);

  logic act0, act1, done0, done1;

  always_comb begin
    act0    = v[0] & mem[0];
    act1    = v[1] & mem[1] & ~act0;
    done0   = v[0] & (~mem[0] | cnt_zero);
    done1   = v[1] & (~mem[1] | (act1 & cnt_zero));
    leave[0] = done0;
    leave[1] = done1 & (done0 | ~v[0]);
    handoff  = act0 & done0 & v[1] & mem[1];
    stay     = (v[0] & ~leave[0]) | (v[1] & ~leave[1]);
  end

  // R6: lane 1 never overtakes a held lane 0
  p_order_r6: assert property (@(posedge clk) disable iff (rst)
    (leave[1] && !leave[0]) |-> !v[0]);

  // R5: two memory accesses never finish in the same cycle
  p_serial_r5: assert property (@(posedge clk) disable iff (rst)
    (leave == 2'b11) |-> !(mem[0] && mem[1]));

endmodule

// File: rtl/mem_stage_serializer.sv
module mem_stage_serializer #(
  parameter int TAG_W    = 8,
  parameter int MISS_CYC = 6,
  parameter int HIT_CYC  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       in_v,
  input  logic [1:0]       in_mem,
  input  logic [1:0]       in_miss,
  input  logic [TAG_W-1:0] in_tag0,
  input  logic [TAG_W-1:0] in_tag1,
  output logic             in_ready,
  output logic [1:0]       wb_v,
  output logic [TAG_W-1:0] wb_tag0,
  output logic [TAG_W-1:0] wb_tag1
);
  import mss_pkg::*;

  localparam int CW = cnt_width(MISS_CYC, HIT_CYC);

  logic [1:0]       v_q, mem_q, miss_q;
  logic [TAG_W-1:0] tag0_q, tag1_q;
  logic [CW-1:0]    cnt, load_val, handoff_val;
  logic             cnt_zero, handoff, stay;
  logic [1:0]       leave;

  // First memory access among the incoming pair takes the port at once.
  always_comb begin
    if (in_v[0] && in_mem[0])      load_val = CW'(access_extra(in_miss[0], MISS_CYC, HIT_CYC));
    else if (in_v[1] && in_mem[1]) load_val = CW'(access_extra(in_miss[1], MISS_CYC, HIT_CYC));
    else                           load_val = '0;
    handoff_val = CW'(access_extra(miss_q[1], MISS_CYC, HIT_CYC));
  end

  assign in_ready = ~stay;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q    <= '0;
      mem_q  <= '0;
      miss_q <= '0;
      tag0_q <= '0;
      tag1_q <= '0;
    end else if (in_ready) begin
      v_q    <= in_v;
      mem_q  <= in_mem;
      miss_q <= in_miss;
      tag0_q <= in_tag0;
      tag1_q <= in_tag1;
    end else begin
      v_q <= v_q & ~leave;
    end
  end

  mss_port_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .load(in_ready), .load_val(load_val),
    .handoff(handoff), .handoff_val(handoff_val),
    .cnt(cnt), .cnt_zero(cnt_zero)
  );

  mss_retire u_retire (
    .clk(clk), .rst(rst), .v(v_q), .mem(mem_q), .cnt_zero(cnt_zero),
    .leave(leave), .handoff(handoff), .stay(stay)
  );

  assign wb_v    = leave;
  assign wb_tag0 = tag0_q;
  assign wb_tag1 = tag1_q;

  // R7: a stalled stage keeps its held tags
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> ($stable(tag0_q) && $stable(tag1_q)));

  // R3: a lane-0 hit leaves in the first cycle
  p_hit_one_r3: assert property (@(posedge clk) disable iff (rst)
    (in_ready && in_v[0] && in_mem[0] && !in_miss[0]) |=> wb_v[0]);

  // R2: a pair of non-memory instructions leaves together at once
  p_nonmem_pass_r2: assert property (@(posedge clk) disable iff (rst)
    (in_ready && in_v == 2'b11 && in_mem == 2'b00) |=> (wb_v == 2'b11));

endmodule

// File: tb/mem_stage_serializer_test.sv
module mem_stage_serializer_test;
  localparam int TW = 8;
  localparam int MISS = 6;

  logic clk = 0;
  logic rst = 1;
  logic [1:0] in_v = 0, in_mem = 0, in_miss = 0;
  logic [TW-1:0] in_tag0 = 0, in_tag1 = 0;
  logic in_ready;
  logic [1:0] wb_v;
  logic [TW-1:0] wb_tag0, wb_tag1;

  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  mem_stage_serializer #(.TAG_W(TW), .MISS_CYC(MISS), .HIT_CYC(1)) uut (
    .clk(clk), .rst(rst), .in_v(in_v), .in_mem(in_mem), .in_miss(in_miss),
    .in_tag0(in_tag0), .in_tag1(in_tag1), .in_ready(in_ready),
    .wb_v(wb_v), .wb_tag0(wb_tag0), .wb_tag1(wb_tag1)
  );

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Leave offsets (cycles after acceptance, 0 = first cycle) per requirements.
  function automatic int leave0(input logic [1:0] v, input logic [1:0] m, input logic [1:0] x);
    return (m[0] && x[0]) ? MISS - 1 : 0;
  endfunction

  function automatic int leave1(input logic [1:0] v, input logic [1:0] m, input logic [1:0] x);
    int s, d, e0;
    e0 = leave0(v, m, x);
    if (m[1]) begin
      s = (v[0] && m[0]) ? e0 + 1 : 0;
      d = s + (x[1] ? MISS - 1 : 0);
    end else d = 0;
    return v[0] ? imax(d, e0) : d;
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_pair(input logic [1:0] v, input logic [1:0] m, input logic [1:0] x,
                          input logic [TW-1:0] t0, input logic [TW-1:0] t1, input string req);
    int e0, e1, last;
    logic [1:0] ev;
    e0 = leave0(v, m, x);
    e1 = leave1(v, m, x);
    last = 0;
    if (v[0]) last = imax(last, e0);
    if (v[1]) last = imax(last, e1);
    check(in_ready === 1'b1, req, "ready before pair", in_ready, 1);
    in_v = v; in_mem = m; in_miss = x; in_tag0 = t0; in_tag1 = t1;
    @(posedge clk);
    for (int j = 0; j <= last; j++) begin
      @(negedge clk);
      // R7: junk offered while stalled must be ignored
      in_v = 2'($urandom); in_mem = 2'($urandom); in_miss = 2'($urandom);
      in_tag0 = TW'($urandom); in_tag1 = TW'($urandom);
      ev[0] = v[0] && (j == e0);
      ev[1] = v[1] && (j == e1);
      check(wb_v === ev, req, "wb_v", wb_v, ev);
      check(in_ready === (j == last), "R7", "in_ready", in_ready, (j == last));
      if (ev[0]) check(wb_tag0 === t0, req, "wb_tag0", wb_tag0, t0);
      if (ev[1]) check(wb_tag1 === t1, req, "wb_tag1", wb_tag1, t1);
    end
    in_v = 0;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    @(negedge clk);
    // R1 reset state
    check(wb_v === 2'b00, "R1", "wb_v after reset", wb_v, 0);
    check(in_ready === 1'b1, "R1", "in_ready after reset", in_ready, 1);
    run_pair(2'b11, 2'b00, 2'b00, 8'h11, 8'h12, "R2");   // two non-memory
    run_pair(2'b01, 2'b01, 2'b00, 8'h21, 8'h00, "R3");   // single hit
    run_pair(2'b01, 2'b01, 2'b01, 8'h31, 8'h00, "R4");   // single miss
    run_pair(2'b11, 2'b11, 2'b00, 8'h41, 8'h42, "R5");   // hit then hit
    run_pair(2'b11, 2'b11, 2'b11, 8'h51, 8'h52, "R5");   // miss then miss
    run_pair(2'b11, 2'b01, 2'b01, 8'h61, 8'h62, "R6");   // miss then non-memory
    run_pair(2'b11, 2'b10, 2'b10, 8'h71, 8'h72, "R8");   // non-memory then miss
    run_pair(2'b10, 2'b10, 2'b10, 8'h81, 8'h82, "R8");   // lane 1 alone misses
    run_pair(2'b00, 2'b11, 2'b11, 8'h91, 8'h92, "R9");   // empty pair
    run_pair(2'b11, 2'b11, 2'b10, 8'ha1, 8'ha2, "R5");   // hit then miss
    for (int n = 0; n < 400; n++)
      run_pair(2'($urandom), 2'($urandom), 2'($urandom), TW'($urandom), TW'($urandom), "R6");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule